// File: doc/BRIEF.md
# Step Clock Input Conditioner

This block sits in front of a stepper-motor indexer. It takes three asynchronous control levels (the step clock, the rotation direction and the return-to-origin request) and turns them into clean signals in the system clock domain. Each level passes through a two-flop synchroniser and then a digital noise filter. The filter accepts a new level only after it has been seen for `FILT_LEN` consecutive system-clock samples. Impulse noise shorter than that window is dropped.

An accepted change of the filtered step clock produces a step pulse one system clock wide. The run-time select `risingOnly` decides which changes count. When it is 1, only rising changes produce a step. When it is 0, both rising and falling changes produce a step. Each step pulse carries a copy of the filtered direction level, so the indexer sees a direction that does not move between steps. The filtered return level drives a return request that stays high for as long as the filtered input is high.

The synchronous `runEn` input places the block in hold when it is low. In hold, every synchroniser, filter counter and filtered level is frozen, no step is produced and the outputs keep their values. Filter progress that was made before the hold is kept and resumes afterwards. `FILT_LEN` should be chosen from the system clock frequency so that the window covers the longest glitch to be rejected, which is about 2 µs. Valid step pulses are at least 10 µs wide. The active-low `rstN` clears all state.

Top module: `stepClkConditioner`

## Requirements
- R1: While `rstN` is low and after its release with all inputs low, `stepPulse`, `stepDir` and `retReq` are 0.
- R2: A change of `stepIn` held for at least `FILT_LEN` cycles is accepted. Its step pulse is visible after the (`FILT_LEN`+2)th rising clock edge following the change, and not after the (`FILT_LEN`+1)th.
- R3: A `stepIn` level held for fewer than `FILT_LEN` cycles before returning produces no step pulse.
- R4: With `risingOnly` = 1, each accepted low-to-high change of the step clock gives exactly one pulse, and a high-to-low change gives none.
- R5: With `risingOnly` = 0, each accepted change in either direction gives exactly one pulse.
- R6: `stepPulse` is never high for two consecutive cycles.
- R7: `stepDir` takes the filtered `dirIn` level (1 means one rotation sense, 0 the other) in the cycle `stepPulse` rises. It keeps that value when `dirIn` changes without a step.
- R8: `retReq` follows `retIn` through the same synchroniser and filter. It rises `FILT_LEN`+2 edges after `retIn` rises and stays high while the filtered level is high.
- R9: While `runEn` is 0, no step pulse is produced. `retReq` and `stepDir` keep their values, and changes on `stepIn`, `dirIn` and `retIn` are not sampled.
- R10: Filter progress is frozen in hold and kept. A step change that was one edge short of acceptance when hold began is accepted on the first edge after `runEn` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Synchronous run enable; 0 holds the block |
| risingOnly | input | 1 | 1: step on rising changes only; 0: step on both changes |
| stepIn | input | 1 | Asynchronous step clock |
| dirIn | input | 1 | Asynchronous direction level |
| retIn | input | 1 | Asynchronous return-to-origin level |
| stepPulse | output | 1 | One-cycle step strobe |
| stepDir | output | 1 | Direction captured with the latest step |
| retReq | output | 1 | Filtered return request |

## Verification
Two functions can fall in the same cycle: a filter accepting a step change, and hold taking effect. The bench drops `runEn` exactly one edge before an accepted step would fire. It then checks that no pulse appears during the hold, and that the pending pulse appears on the first edge after release. A second coincidence is a step change and a return change launched on the same cycle. The bench checks that `stepPulse` and `retReq` rise on the same edge, with the latency required of each.

// File: rtl/stepCondPkg.sv
package stepCondPkg;
  // Input channel indices inside the datapath
  localparam int CH_STEP = 0;
  localparam int CH_DIR  = 1;
  localparam int CH_RET  = 2;
  localparam int NUM_CH  = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;  // sample, filter and update this cycle
    logic fire;     // emit a step pulse and capture direction
  } stepStrobes_t;
endpackage

// File: rtl/stepCondFilter.sv
module stepCondFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  input  logic rawIn,
  output logic lvl,
  output logic flipNext
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] cnt;
  logic          differ;

  always_comb begin
    differ   = syncQ[1] ^ lvl;
    flipNext = advance && differ && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      cnt   <= '0;
      lvl   <= 1'b0;
    end else if (advance) begin
      syncQ <= {syncQ[0], rawIn};
      if (!differ || flipNext) cnt <= '0;
      else                     cnt <= cnt + CW'(1);
      if (flipNext) lvl <= ~lvl;
    end
  end
endmodule

// File: rtl/stepCondCtl.sv
module stepCondCtl
  import stepCondPkg::*;
(
  input  logic         runEn,
  input  logic         risingOnly,
  input  logic         stepFlip,
  input  logic         stepLvl,
  output stepStrobes_t strobes
);
  always_comb begin
    strobes.advance = runEn;
    // A flip from a low level is a rising change
    strobes.fire = runEn && stepFlip && (!risingOnly || !stepLvl);
  end
endmodule

// File: rtl/stepCondPath.sv
module stepCondPath
  import stepCondPkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIn,
  input  stepStrobes_t      strobes,
  output logic              stepFlip,
  output logic              stepLvl,
  output logic              stepPulse,
  output logic              stepDir,
  output logic              retReq
);
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] flip;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    stepCondFilter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .advance  (strobes.advance),
      .rawIn    (rawIn[i]),
      .lvl      (lvl[i]),
      .flipNext (flip[i])
    );
  end

  always_comb begin
    stepFlip = flip[CH_STEP];
    stepLvl  = lvl[CH_STEP];
    retReq   = lvl[CH_RET];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPulse <= 1'b0;
      stepDir   <= 1'b0;
    end else begin
      stepPulse <= strobes.fire;
      if (strobes.fire) stepDir <= lvl[CH_DIR];
    end
  end
endmodule

// File: rtl/stepClkConditioner.sv
module stepClkConditioner
  import stepCondPkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic risingOnly,
  input  logic stepIn,
  input  logic dirIn,
  input  logic retIn,
  output logic stepPulse,
  output logic stepDir,
  output logic retReq
);
  stepStrobes_t      strobes;
  logic              stepFlip;
  logic              stepLvl;
  logic [NUM_CH-1:0] rawIn;

  always_comb begin
    rawIn          = '0;
    rawIn[CH_STEP] = stepIn;
    rawIn[CH_DIR]  = dirIn;
    rawIn[CH_RET]  = retIn;
  end

  stepCondCtl u_ctl (
    .runEn      (runEn),
    .risingOnly (risingOnly),
    .stepFlip   (stepFlip),
    .stepLvl    (stepLvl),
    .strobes    (strobes)
  );

  stepCondPath #(.FILT_LEN(FILT_LEN)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .rawIn     (rawIn),
    .strobes   (strobes),
    .stepFlip  (stepFlip),
    .stepLvl   (stepLvl),
    .stepPulse (stepPulse),
    .stepDir   (stepDir),
    .retReq    (retReq)
  );
endmodule

// File: rtl/stepCondChecker.sv
module stepCondChecker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic risingOnly,
  input logic stepPulse,
  input logic stepDir,
  input logic retReq,
  input logic stepLvl
);
  // R6: strobe never lasts two cycles
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> !stepPulse);

  // R4: in rising-only mode a pulse follows a low-to-high filtered change
  a_r4_rising_level: assert property (@(posedge clk) disable iff (!rstN)
    (stepPulse && $past(risingOnly)) |-> stepLvl);

  // R7: direction moves only together with a step
  a_r7_dir_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stepPulse |-> $stable(stepDir));

  // R9: hold suppresses pulses
  a_r9_hold_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !stepPulse);

  // R9: hold freezes the return request
  a_r9_hold_ret_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> $stable(retReq));
endmodule

bind stepClkConditioner stepCondChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .runEn      (runEn),
  .risingOnly (risingOnly),
  .stepPulse  (stepPulse),
  .stepDir    (stepDir),
  .retReq     (retReq),
  .stepLvl    (stepLvl)
);

// File: tb/sim_stepClkConditioner.sv
`timescale 1ns/1ps
module sim_stepClkConditioner;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b1;
  logic risingOnly = 1'b0;
  logic stepIn = 1'b0;
  logic dirIn = 1'b0;
  logic retIn = 1'b0;
  logic stepPulse, stepDir, retReq;

  int testCnt = 0;
  int failCnt = 0;
  int pulseCnt = 0;
  int doubleCnt = 0;
  logic prevPulse = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stepClkConditioner #(.FILT_LEN(N)) u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .risingOnly(risingOnly),
    .stepIn(stepIn), .dirIn(dirIn), .retIn(retIn),
    .stepPulse(stepPulse), .stepDir(stepDir), .retReq(retReq)
  );

  // Pulse monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (stepPulse) pulseCnt = pulseCnt + 1;
    if (stepPulse && prevPulse) doubleCnt = doubleCnt + 1;
    prevPulse = stepPulse;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int base;
    int expPulses;
    // R1: reset state
    cyc(3);
    check(!stepPulse && !stepDir && !retReq, "R1 in reset", {stepPulse, stepDir, retReq}, 0);
    rstN = 1'b1;
    cyc(N + 4);
    check(!stepPulse && !stepDir && !retReq, "R1 after reset", {stepPulse, stepDir, retReq}, 0);

    // R2 latency and R8 return latency, launched together
    risingOnly = 1'b0;
    stepIn = 1'b1;
    retIn = 1'b1;
    cyc(N + 1);
    check(stepPulse == 1'b0, "R2 no pulse at N+1", stepPulse, 0);
    check(retReq == 1'b0, "R8 no request at N+1", retReq, 0);
    cyc(1);
    check(stepPulse == 1'b1, "R2 pulse at N+2", stepPulse, 1);
    check(retReq == 1'b1, "R8 request at N+2", retReq, 1);
    cyc(1);
    check(stepPulse == 1'b0, "R6 pulse one cycle", stepPulse, 0);
    check(retReq == 1'b1, "R8 request held", retReq, 1);
    retIn = 1'b0;
    stepIn = 1'b0;
    cyc(N + 2);
    check(retReq == 1'b0, "R8 request drops", retReq, 0);
    cyc(N + 4);

    // R3/R4/R5: width sweep in both edge modes
    for (int ro = 0; ro < 2; ro++) begin
      for (int w = 1; w <= N + 2; w++) begin
        risingOnly = ro[0];
        cyc(2);
        base = pulseCnt;
        stepIn = 1'b1;
        cyc(w);
        stepIn = 1'b0;
        cyc(2 * N + 6);
        expPulses = (w < N) ? 0 : (ro == 1 ? 1 : 2);
        if (w < N)
          check(pulseCnt - base == expPulses, "R3 short glitch", pulseCnt - base, expPulses);
        else if (ro == 1)
          check(pulseCnt - base == expPulses, "R4 rising only", pulseCnt - base, expPulses);
        else
          check(pulseCnt - base == expPulses, "R5 both edges", pulseCnt - base, expPulses);
      end
    end
    check(doubleCnt == 0, "R6 no double pulse", doubleCnt, 0);

    // R7: direction capture
    risingOnly = 1'b0;
    dirIn = 1'b1;
    cyc(N + 4);
    stepIn = 1'b1;
    cyc(N + 3);
    check(stepDir == 1'b1, "R7 direction captured", stepDir, 1);
    dirIn = 1'b0;
    cyc(2 * N + 6);
    check(stepDir == 1'b1, "R7 direction held without step", stepDir, 1);
    stepIn = 1'b0;
    cyc(N + 3);
    check(stepDir == 1'b0, "R7 new direction on next step", stepDir, 0);

    // R9: hold ignores input activity
    runEn = 1'b0;
    cyc(1);
    base = pulseCnt;
    retIn = 1'b1;
    dirIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      stepIn = ~stepIn;
      cyc(N + 3);
    end
    check(pulseCnt == base, "R9 no pulse in hold", pulseCnt - base, 0);
    check(retReq == 1'b0, "R9 request frozen", retReq, 0);
    check(stepDir == 1'b0, "R9 direction frozen", stepDir, 0);
    retIn = 1'b0;
    dirIn = 1'b0;
    cyc(1);
    runEn = 1'b1;
    cyc(2 * N + 6);
    check(pulseCnt == base, "R9 nothing after resume", pulseCnt - base, 0);
    check(retReq == 1'b0, "R9 request after resume", retReq, 0);

    // R10: hold lands one edge before acceptance
    risingOnly = 1'b1;
    base = pulseCnt;
    stepIn = 1'b1;
    cyc(N + 1);
    runEn = 1'b0;
    cyc(10);
    check(pulseCnt == base, "R10 pending pulse held back", pulseCnt - base, 0);
    runEn = 1'b1;
    cyc(1);
    check(stepPulse == 1'b1, "R10 pulse on first edge after resume", stepPulse, 1);
    cyc(1);
    check(stepPulse == 1'b0, "R6 resumed pulse one cycle", stepPulse, 0);
    stepIn = 1'b0;
    cyc(2 * N + 6);
    check(pulseCnt - base == 1, "R4 falling ignored after resume", pulseCnt - base, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule